// File: doc/BRIEF.md
# Software-Loaded Translation Buffer with Miss Exceptions

This block holds a small, fully associative set of page translations that software alone maintains. It serves two lookup paths, one for instruction fetch and one for data access. Each path presents an effective address, the running process identifier and, on the data side, an access kind. A lookup compares the request against every valid entry in the same cycle and returns a hit flag and a physical address. When translation is on for that side and nothing matches, the block raises a one-cycle miss exception on the next clock. It also records the faulting address in the register that belongs to that side.

There is no hardware table walk and no replacement. Entries change only through an indexed write port and an invalidate-all command, so software decides what stays resident. The strap input `mmu_en` can disable the whole unit. While it is low, TLB-management opcodes are reported as illegal, the relocation enables read as zero whatever software loads into them, and the write and invalidate commands are ignored.

Lookups never stall. A request is taken in any cycle its valid strobe is high, and results are not held back, so the stream handshake is reduced to a valid strobe with no ready.

Top module: `tlb_miss_unit`

## Requirements
- R1: An entry matches when it is valid, its page number equals address bits [31:12], and its process field is 0 or equals the request's process ID. `if_hit`/`d_hit` is high when the lookup is valid and an entry matches. If several entries match, the lowest index supplies the real page number.
- R2: If `if_valid` is high, the instruction relocation enable `xlat_ir` is 1 and no entry matches, `itlb_exc` is high for exactly the next cycle, and `srr0` then holds the fetch address.
- R3: Data access kinds are 0 for a load/store, 1 for cache management, 2 for cache touch and 3 reserved. If `d_valid` is high, `xlat_dr` is 1, no entry matches and the kind is not 2, `dtlb_exc` pulses on the next cycle and `dear` then holds the data address. Kind 2 never raises `dtlb_exc`.
- R4: When a side's relocation enable is 0, that side raises no miss exception and its physical address output equals its effective address. When the enable is 1 and the lookup hits, the output is the real page number concatenated with address bits [11:0].
- R5: If both sides miss in the same cycle, only `itlb_exc` pulses and only `srr0` is updated. `dtlb_exc` stays low and `dear` keeps its old value.
- R6: While `tlb_we` is high, the entry at `tlb_widx` loads valid, page number, process ID and real page number at the clock edge. A lookup in that same cycle sees the old contents.
- R7: `tlb_inval_all` clears every valid bit at the clock edge. A write in the same cycle is applied after the clear, so the written entry survives.
- R8: With `mmu_en` 0, an `op_valid` carrying `op_code` 1 (invalidate-all), 2 (read), 3 (search), 4 (sync) or 5 (write) makes `prog_exc` pulse on the next cycle. Codes 0, 6 and 7, or `mmu_en` 1, never raise it.
- R9: With `mmu_en` 0, `xlat_ir` and `xlat_dr` read 0 at all times, including after `reloc_load` presents 1 values, as it does on a return from interrupt.
- R10: With `mmu_en` 0, `tlb_we` and `tlb_inval_all` have no effect on the entry array.
- R11: After reset, every entry is invalid and `itlb_exc`, `dtlb_exc`, `prog_exc`, `srr0`, `dear`, `xlat_ir` and `xlat_dr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmu_en | input | 1 | Strap; 0 disables the translation unit |
| reloc_load | input | 1 | Load the relocation enables (state write or interrupt return) |
| reloc_ir_d | input | 1 | Instruction relocation value to load |
| reloc_dr_d | input | 1 | Data relocation value to load |
| xlat_ir | output | 1 | Effective instruction relocation enable |
| xlat_dr | output | 1 | Effective data relocation enable |
| op_valid | input | 1 | An opcode is being decoded |
| op_code | input | 3 | Opcode class; 1 to 5 are TLB management |
| prog_exc | output | 1 | Illegal-instruction program exception pulse |
| if_valid | input | 1 | Instruction lookup strobe |
| if_ea | input | 32 | Fetch effective address |
| if_pid | input | 8 | Process ID for the fetch |
| if_hit | output | 1 | Fetch matched an entry |
| if_pa | output | 32 | Fetch physical address |
| d_valid | input | 1 | Data lookup strobe |
| d_ea | input | 32 | Data effective address |
| d_pid | input | 8 | Process ID for the access |
| d_kind | input | 2 | Access kind (0 load/store, 1 cache mgmt, 2 touch) |
| d_hit | output | 1 | Data access matched an entry |
| d_pa | output | 32 | Data physical address |
| tlb_we | input | 1 | Entry write strobe |
| tlb_widx | input | 3 | Entry index to write |
| tlb_wvalid | input | 1 | Valid bit to write |
| tlb_wepn | input | 20 | Effective page number to write |
| tlb_wpid | input | 8 | Process ID to write (0 means any) |
| tlb_wrpn | input | 20 | Real page number to write |
| tlb_inval_all | input | 1 | Clear all valid bits |
| itlb_exc | output | 1 | Instruction miss exception pulse |
| dtlb_exc | output | 1 | Data miss exception pulse |
| srr0 | output | 32 | Address of the last instruction miss |
| dear | output | 32 | Address of the last data miss |

## Verification
The entry array cannot be read directly, so any corruption of it, such as a dropped valid bit, a wrong process field, or a write to the wrong index, appears only through lookups. It shows at `if_hit`/`d_hit` and the physical address in the same cycle as the next lookup that touches the entry, and as a spurious or missing exception one clock later. A fault in the relocation or strap state shows at `xlat_ir`/`xlat_dr` right away. A wrong choice of exception side shows in the pulse pair and in which of `srr0`/`dear` moves, one clock after the miss. The bench therefore loads a known set of entries, including a global one and an overlapping one, and probes each through both paths.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  typedef enum logic [1:0] {
    ACC_LDST  = 2'd0,
    ACC_CMGT  = 2'd1,
    ACC_TOUCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_INVALL = 3'd1,
    OP_READ   = 3'd2,
    OP_SEARCH = 3'd3,
    OP_SYNC   = 3'd4,
    OP_WRITE  = 3'd5,
    OP_OTH6   = 3'd6,
    OP_OTH7   = 3'd7
  } tlbop_e;

  function automatic logic is_tlb_op(input logic [2:0] code);
    return (code >= OP_INVALL) && (code <= OP_WRITE);
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int ENTRIES = 8,
  parameter int EPN_W   = 20,
  parameter int PID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic                            wr_valid,
  input  logic [EPN_W-1:0]                wr_epn,
  input  logic [PID_W-1:0]                wr_pid,
  input  logic [EPN_W-1:0]                wr_rpn,
  input  logic                            clr_all,
  output logic [ENTRIES-1:0]              ent_v,
  output logic [ENTRIES-1:0][EPN_W-1:0]   ent_epn,
  output logic [ENTRIES-1:0][PID_W-1:0]   ent_pid,
  output logic [ENTRIES-1:0][EPN_W-1:0]   ent_rpn
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_v[g] <= 1'b0;
      end else if (sel) begin
        ent_v[g] <= wr_valid;
      end else if (clr_all) begin
        ent_v[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_epn[g] <= '0;
        ent_pid[g] <= '0;
        ent_rpn[g] <= '0;
      end else if (sel) begin
        ent_epn[g] <= wr_epn;
        ent_pid[g] <= wr_pid;
        ent_rpn[g] <= wr_rpn;
      end
    end
  end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup #(
  parameter int ENTRIES = 8,
  parameter int EPN_W   = 20,
  parameter int PID_W   = 8
) (
  input  logic [ENTRIES-1:0]              ent_v,
  input  logic [ENTRIES-1:0][EPN_W-1:0]   ent_epn,
  input  logic [ENTRIES-1:0][PID_W-1:0]   ent_pid,
  input  logic [ENTRIES-1:0][EPN_W-1:0]   ent_rpn,
  input  logic [EPN_W-1:0]                req_epn,
  input  logic [PID_W-1:0]                req_pid,
  output logic                            match,
  output logic [EPN_W-1:0]                rpn
);
  logic [ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic pid_ok;
    assign pid_ok     = (ent_pid[g] == '0) || (ent_pid[g] == req_pid);
    assign hit_vec[g] = ent_v[g] && pid_ok && (ent_epn[g] == req_epn);
  end

  // lowest matching index wins: scan from the top so lower indices overwrite
  always_comb begin
    rpn = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (hit_vec[k]) rpn = ent_rpn[k];
    end
  end

  assign match = |hit_vec;
endmodule

// File: rtl/tlb_except_ctrl.sv
module tlb_except_ctrl #(
  parameter int EA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            i_miss,
  input  logic            d_miss,
  input  logic [EA_W-1:0] i_ea,
  input  logic [EA_W-1:0] d_ea,
  output logic            itlb_exc,
  output logic            dtlb_exc,
  output logic [EA_W-1:0] srr0,
  output logic [EA_W-1:0] dear
);
  logic d_take;
  assign d_take = d_miss && !i_miss;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      itlb_exc <= 1'b0;
      dtlb_exc <= 1'b0;
      srr0     <= '0;
      dear     <= '0;
    end else begin
      itlb_exc <= i_miss;
      dtlb_exc <= d_take;
      if (i_miss) srr0 <= i_ea;
      if (d_take) dear <= d_ea;
    end
  end
endmodule

// File: rtl/tlb_miss_unit.sv
module tlb_miss_unit
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int EA_W    = 32,
  parameter int PG_W    = 12,
  parameter int PID_W   = 8,
  localparam int EPN_W  = EA_W - PG_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mmu_en,
  input  logic             reloc_load,
  input  logic             reloc_ir_d,
  input  logic             reloc_dr_d,
  output logic             xlat_ir,
  output logic             xlat_dr,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  output logic             prog_exc,
  input  logic             if_valid,
  input  logic [EA_W-1:0]  if_ea,
  input  logic [PID_W-1:0] if_pid,
  output logic             if_hit,
  output logic [EA_W-1:0]  if_pa,
  input  logic             d_valid,
  input  logic [EA_W-1:0]  d_ea,
  input  logic [PID_W-1:0] d_pid,
  input  logic [1:0]       d_kind,
  output logic             d_hit,
  output logic [EA_W-1:0]  d_pa,
  input  logic             tlb_we,
  input  logic [IDX_W-1:0] tlb_widx,
  input  logic             tlb_wvalid,
  input  logic [EPN_W-1:0] tlb_wepn,
  input  logic [PID_W-1:0] tlb_wpid,
  input  logic [EPN_W-1:0] tlb_wrpn,
  input  logic             tlb_inval_all,
  output logic             itlb_exc,
  output logic             dtlb_exc,
  output logic [EA_W-1:0]  srr0,
  output logic [EA_W-1:0]  dear
);
  logic [ENTRIES-1:0]            ent_v;
  logic [ENTRIES-1:0][EPN_W-1:0] ent_epn;
  logic [ENTRIES-1:0][PID_W-1:0] ent_pid;
  logic [ENTRIES-1:0][EPN_W-1:0] ent_rpn;
  logic                          ir_q, dr_q;
  logic                          prog_q;
  logic                          i_match, d_match;
  logic [EPN_W-1:0]              i_rpn, d_rpn;
  logic                          i_miss, d_miss;

  // relocation enables: cleared and held low while the strap is off
  always_ff @(posedge clk) begin
    if (!rst_n || !mmu_en) begin
      ir_q <= 1'b0;
      dr_q <= 1'b0;
    end else if (reloc_load) begin
      ir_q <= reloc_ir_d;
      dr_q <= reloc_dr_d;
    end
  end
  assign xlat_ir = ir_q && mmu_en;
  assign xlat_dr = dr_q && mmu_en;

  always_ff @(posedge clk) begin
    if (!rst_n) prog_q <= 1'b0;
    else        prog_q <= op_valid && !mmu_en && is_tlb_op(op_code);
  end
  assign prog_exc = prog_q;

  tlb_entry_store #(.ENTRIES(ENTRIES), .EPN_W(EPN_W), .PID_W(PID_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tlb_we && mmu_en),
    .wr_idx  (tlb_widx),
    .wr_valid(tlb_wvalid),
    .wr_epn  (tlb_wepn),
    .wr_pid  (tlb_wpid),
    .wr_rpn  (tlb_wrpn),
    .clr_all (tlb_inval_all && mmu_en),
    .ent_v   (ent_v),
    .ent_epn (ent_epn),
    .ent_pid (ent_pid),
    .ent_rpn (ent_rpn)
  );

  tlb_lookup #(.ENTRIES(ENTRIES), .EPN_W(EPN_W), .PID_W(PID_W)) u_ilook (
    .ent_v  (ent_v),
    .ent_epn(ent_epn),
    .ent_pid(ent_pid),
    .ent_rpn(ent_rpn),
    .req_epn(if_ea[EA_W-1:PG_W]),
    .req_pid(if_pid),
    .match  (i_match),
    .rpn    (i_rpn)
  );

  tlb_lookup #(.ENTRIES(ENTRIES), .EPN_W(EPN_W), .PID_W(PID_W)) u_dlook (
    .ent_v  (ent_v),
    .ent_epn(ent_epn),
    .ent_pid(ent_pid),
    .ent_rpn(ent_rpn),
    .req_epn(d_ea[EA_W-1:PG_W]),
    .req_pid(d_pid),
    .match  (d_match),
    .rpn    (d_rpn)
  );

  assign if_hit = if_valid && i_match;
  assign d_hit  = d_valid && d_match;
  assign if_pa  = (xlat_ir && i_match) ? {i_rpn, if_ea[PG_W-1:0]} : if_ea;
  assign d_pa   = (xlat_dr && d_match) ? {d_rpn, d_ea[PG_W-1:0]} : d_ea;

  assign i_miss = if_valid && xlat_ir && !i_match;
  assign d_miss = d_valid && xlat_dr && !d_match && (d_kind != ACC_TOUCH);

  tlb_except_ctrl #(.EA_W(EA_W)) u_exc (
    .clk     (clk),
    .rst_n   (rst_n),
    .i_miss  (i_miss),
    .d_miss  (d_miss),
    .i_ea    (if_ea),
    .d_ea    (d_ea),
    .itlb_exc(itlb_exc),
    .dtlb_exc(dtlb_exc),
    .srr0    (srr0),
    .dear    (dear)
  );
endmodule

// File: rtl/tlb_miss_unit_chk.sv
module tlb_miss_unit_chk #(
  parameter int EA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mmu_en,
  input logic            xlat_ir,
  input logic            xlat_dr,
  input logic            op_valid,
  input logic [2:0]      op_code,
  input logic            prog_exc,
  input logic            if_valid,
  input logic [EA_W-1:0] if_ea,
  input logic            d_valid,
  input logic [EA_W-1:0] d_ea,
  input logic [1:0]      d_kind,
  input logic            itlb_exc,
  input logic            dtlb_exc,
  input logic [EA_W-1:0] srr0,
  input logic [EA_W-1:0] dear
);
  // R9
  strap_reloc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mmu_en |-> (!xlat_ir && !xlat_dr));

  // R5
  one_side_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(itlb_exc && dtlb_exc));

  // R2
  srr0_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    itlb_exc |-> (srr0 == $past(if_ea)));

  // R2
  srr0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !itlb_exc |-> $stable(srr0));

  // R3
  dear_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dtlb_exc |-> (dear == $past(d_ea)));

  // R3
  touch_no_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && d_kind == 2'd2) |=> !dtlb_exc);

  // R8
  prog_only_strap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_exc |-> ($past(op_valid) && !$past(mmu_en)));
endmodule

bind tlb_miss_unit tlb_miss_unit_chk #(.EA_W(EA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mmu_en  (mmu_en),
  .xlat_ir (xlat_ir),
  .xlat_dr (xlat_dr),
  .op_valid(op_valid),
  .op_code (op_code),
  .prog_exc(prog_exc),
  .if_valid(if_valid),
  .if_ea   (if_ea),
  .d_valid (d_valid),
  .d_ea    (d_ea),
  .d_kind  (d_kind),
  .itlb_exc(itlb_exc),
  .dtlb_exc(dtlb_exc),
  .srr0    (srr0),
  .dear    (dear)
);

// File: tb/tb_tlb_miss_unit.sv
module tb_tlb_miss_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  typedef struct packed {
    logic        side;   // 0 fetch, 1 data
    logic [31:0] ea;
    logic [7:0]  pid;
    logic [1:0]  kind;
    logic        hit;
    logic [31:0] pa;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0001_0ABC, 8'd5,   2'd0, 1'b1, 32'h8001_0ABC},
    '{1'b0, 32'h0001_0ABC, 8'd9,   2'd0, 1'b1, 32'hB001_0ABC},
    '{1'b0, 32'h0001_0ABC, 8'd6,   2'd0, 1'b0, 32'h0},
    '{1'b1, 32'h0002_0123, 8'd200, 2'd0, 1'b1, 32'h9002_0123},
    '{1'b1, 32'h0003_0FFF, 8'd7,   2'd1, 1'b1, 32'hA003_0FFF},
    '{1'b1, 32'h0003_0FFF, 8'd8,   2'd0, 1'b0, 32'h0},
    '{1'b1, 32'h0004_0000, 8'd5,   2'd2, 1'b0, 32'h0},
    '{1'b1, 32'h0004_0000, 8'd5,   2'd1, 1'b0, 32'h0},
    '{1'b0, 32'h0005_0000, 8'd0,   2'd0, 1'b0, 32'h0},
    '{1'b1, 32'h0002_0444, 8'd3,   2'd0, 1'b1, 32'h9002_0444}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mmu_en = 1'b1;
  logic        reloc_load = 1'b0, reloc_ir_d = 1'b0, reloc_dr_d = 1'b0;
  logic        xlat_ir, xlat_dr;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic        prog_exc;
  logic        if_valid = 1'b0;
  logic [31:0] if_ea = '0;
  logic [7:0]  if_pid = '0;
  logic        if_hit;
  logic [31:0] if_pa;
  logic        d_valid = 1'b0;
  logic [31:0] d_ea = '0;
  logic [7:0]  d_pid = '0;
  logic [1:0]  d_kind = '0;
  logic        d_hit;
  logic [31:0] d_pa;
  logic        tlb_we = 1'b0;
  logic [2:0]  tlb_widx = '0;
  logic        tlb_wvalid = 1'b0;
  logic [19:0] tlb_wepn = '0;
  logic [7:0]  tlb_wpid = '0;
  logic [19:0] tlb_wrpn = '0;
  logic        tlb_inval_all = 1'b0;
  logic        itlb_exc, dtlb_exc;
  logic [31:0] srr0, dear;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_miss_unit dut (
    .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en),
    .reloc_load(reloc_load), .reloc_ir_d(reloc_ir_d), .reloc_dr_d(reloc_dr_d),
    .xlat_ir(xlat_ir), .xlat_dr(xlat_dr),
    .op_valid(op_valid), .op_code(op_code), .prog_exc(prog_exc),
    .if_valid(if_valid), .if_ea(if_ea), .if_pid(if_pid), .if_hit(if_hit), .if_pa(if_pa),
    .d_valid(d_valid), .d_ea(d_ea), .d_pid(d_pid), .d_kind(d_kind), .d_hit(d_hit), .d_pa(d_pa),
    .tlb_we(tlb_we), .tlb_widx(tlb_widx), .tlb_wvalid(tlb_wvalid), .tlb_wepn(tlb_wepn),
    .tlb_wpid(tlb_wpid), .tlb_wrpn(tlb_wrpn), .tlb_inval_all(tlb_inval_all),
    .itlb_exc(itlb_exc), .dtlb_exc(dtlb_exc), .srr0(srr0), .dear(dear)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_ent(input logic [2:0] idx, input logic [19:0] epn,
                           input logic [7:0] pid, input logic [19:0] rpn);
    @(negedge clk);
    tlb_we = 1'b1; tlb_widx = idx; tlb_wvalid = 1'b1;
    tlb_wepn = epn; tlb_wpid = pid; tlb_wrpn = rpn;
    @(negedge clk);
    tlb_we = 1'b0;
  endtask

  task automatic set_reloc(input logic ir, input logic dr);
    @(negedge clk);
    reloc_load = 1'b1; reloc_ir_d = ir; reloc_dr_d = dr;
    @(negedge clk);
    reloc_load = 1'b0;
  endtask

  task automatic data_probe(input logic [31:0] ea, input logic [7:0] pid,
                            output logic hit, output logic [31:0] pa);
    @(negedge clk);
    d_valid = 1'b1; d_ea = ea; d_pid = pid; d_kind = 2'd0;
    #1;
    hit = d_hit; pa = d_pa;
    @(negedge clk);
    d_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic        h;
    logic [31:0] p;
    logic [31:0] dear_prev;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 itlb_exc", {31'b0, itlb_exc}, 32'd0);
    check("R11 dtlb_exc", {31'b0, dtlb_exc}, 32'd0);
    check("R11 prog_exc", {31'b0, prog_exc}, 32'd0);
    check("R11 srr0", srr0, 32'd0);
    check("R11 dear", dear, 32'd0);
    check("R11 xlat", {30'b0, xlat_ir, xlat_dr}, 32'd0);
    data_probe(32'h0000_0000, 8'd0, h, p);
    check("R11 empty array", {31'b0, h}, 32'd0);

    write_ent(3'd0, 20'h00010, 8'd5, 20'h80010);
    write_ent(3'd1, 20'h00020, 8'd0, 20'h90020);
    write_ent(3'd2, 20'h00030, 8'd7, 20'hA0030);
    write_ent(3'd3, 20'h00010, 8'd9, 20'hB0010);
    write_ent(3'd6, 20'h00020, 8'd3, 20'hC0020);
    set_reloc(1'b1, 1'b1);
    check("R9 reloc load with strap on", {30'b0, xlat_ir, xlat_dr}, 32'd3);

    // R1 R2 R3 R4: table walk
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      logic iexp, dexp;
      v = VECS[k];
      iexp = (v.side == 1'b0) && !v.hit;
      dexp = (v.side == 1'b1) && !v.hit && (v.kind != 2'd2);
      @(negedge clk);
      if (v.side == 1'b0) begin
        if_valid = 1'b1; if_ea = v.ea; if_pid = v.pid;
      end else begin
        d_valid = 1'b1; d_ea = v.ea; d_pid = v.pid; d_kind = v.kind;
      end
      #1;
      if (v.side == 1'b0) begin
        check("R1 fetch hit", {31'b0, if_hit}, {31'b0, v.hit});
        if (v.hit) check("R4 fetch pa", if_pa, v.pa);
      end else begin
        check("R1 data hit", {31'b0, d_hit}, {31'b0, v.hit});
        if (v.hit) check("R4 data pa", d_pa, v.pa);
      end
      @(negedge clk);
      if_valid = 1'b0; d_valid = 1'b0;
      check("R2 itlb_exc", {31'b0, itlb_exc}, {31'b0, iexp});
      check("R3 dtlb_exc", {31'b0, dtlb_exc}, {31'b0, dexp});
      if (iexp) check("R2 srr0", srr0, v.ea);
      if (dexp) check("R3 dear", dear, v.ea);
    end

    // R4 translation off: no exceptions, pa equals ea
    set_reloc(1'b0, 1'b0);
    @(negedge clk);
    if_valid = 1'b1; if_ea = 32'h0009_9123; if_pid = 8'd1;
    d_valid = 1'b1; d_ea = 32'h0008_8456; d_pid = 8'd1; d_kind = 2'd0;
    #1;
    check("R4 fetch pa untranslated", if_pa, 32'h0009_9123);
    check("R4 data pa untranslated", d_pa, 32'h0008_8456);
    @(negedge clk);
    if_valid = 1'b0; d_valid = 1'b0;
    check("R4 no exc when off", {30'b0, itlb_exc, dtlb_exc}, 32'd0);
    set_reloc(1'b1, 1'b1);

    // R5 simultaneous misses
    dear_prev = dear;
    @(negedge clk);
    if_valid = 1'b1; if_ea = 32'h000A_0000; if_pid = 8'd1;
    d_valid = 1'b1; d_ea = 32'h000B_0000; d_pid = 8'd1; d_kind = 2'd0;
    @(negedge clk);
    if_valid = 1'b0; d_valid = 1'b0;
    check("R5 itlb wins", {30'b0, itlb_exc, dtlb_exc}, 32'd2);
    check("R5 srr0", srr0, 32'h000A_0000);
    check("R5 dear unchanged", dear, dear_prev);

    // R6 write with same-cycle lookup
    @(negedge clk);
    tlb_we = 1'b1; tlb_widx = 3'd4; tlb_wvalid = 1'b1;
    tlb_wepn = 20'h00060; tlb_wpid = 8'd0; tlb_wrpn = 20'hD0060;
    d_valid = 1'b1; d_ea = 32'h0006_0010; d_pid = 8'd1; d_kind = 2'd0;
    #1;
    check("R6 same-cycle sees old", {31'b0, d_hit}, 32'd0);
    @(negedge clk);
    tlb_we = 1'b0;
    check("R6 after write hit", {31'b0, d_hit}, 32'd1);
    check("R6 after write pa", d_pa, 32'hD006_0010);
    d_valid = 1'b0;

    // R8 R9 R10 strap off
    @(negedge clk);
    mmu_en = 1'b0;
    #1;
    check("R9 strap off immediate", {30'b0, xlat_ir, xlat_dr}, 32'd0);
    set_reloc(1'b1, 1'b1);
    check("R9 strap off after return load", {30'b0, xlat_ir, xlat_dr}, 32'd0);
    for (int c = 0; c < 8; c++) begin
      logic exp_p;
      exp_p = (c >= 1) && (c <= 5);
      @(negedge clk);
      op_valid = 1'b1; op_code = 3'(c);
      @(negedge clk);
      op_valid = 1'b0;
      check("R8 prog_exc strap off", {31'b0, prog_exc}, {31'b0, exp_p});
    end
    write_ent(3'd5, 20'h00070, 8'd0, 20'hE0070);
    @(negedge clk);
    tlb_inval_all = 1'b1;
    @(negedge clk);
    tlb_inval_all = 1'b0;
    mmu_en = 1'b1;
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd5;
    @(negedge clk);
    op_valid = 1'b0;
    check("R8 no prog_exc strap on", {31'b0, prog_exc}, 32'd0);
    set_reloc(1'b1, 1'b1);
    data_probe(32'h0007_0000, 8'd1, h, p);
    check("R10 write ignored", {31'b0, h}, 32'd0);
    data_probe(32'h0001_0000, 8'd5, h, p);
    check("R10 invalidate ignored", {31'b0, h}, 32'd1);

    // R7 invalidate-all with a same-cycle write
    @(negedge clk);
    tlb_inval_all = 1'b1;
    tlb_we = 1'b1; tlb_widx = 3'd2; tlb_wvalid = 1'b1;
    tlb_wepn = 20'h000F0; tlb_wpid = 8'd0; tlb_wrpn = 20'hF00F0;
    @(negedge clk);
    tlb_inval_all = 1'b0; tlb_we = 1'b0;
    data_probe(32'h0001_0000, 8'd5, h, p);
    check("R7 entry cleared", {31'b0, h}, 32'd0);
    data_probe(32'h0002_0000, 8'd1, h, p);
    check("R7 global entry cleared", {31'b0, h}, 32'd0);
    data_probe(32'h000F_0ABC, 8'd4, h, p);
    check("R7 written entry survives", {31'b0, h}, 32'd1);
    check("R7 written entry pa", p, 32'hF00F_0ABC);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule